// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer

This peripheral holds a 32-bit counter that climbs by one on each enabled count tick while the timer runs. When the count passes its maximum and wraps, the counter takes the value held in the load register and an overflow flag is raised. In one-shot operation the timer then halts by itself. In auto-reload operation it keeps counting from the reloaded value. An optional power-of-two prescaler slows the count, a compare unit can end the period early at a programmed match value, and a capture unit samples the counter when a chosen edge arrives on an external pin.

Software reaches the block through a simple word-wide register port. Writes take effect at the clock edge, and reads are combinational from the address. Three event sources (capture, overflow, match) each latch a status flag. Software clears a flag by writing a one to it. A per-source enable mask combines the flags into one level interrupt.

The run control is a two-state machine. HALT moves to RUN when the control register is written with its start bit set. RUN moves back to HALT when the control register is written with the start bit clear, or on a wrap while auto-reload is off. The start bit reads back as the current state.

Top module: `gpt_timer`

## Requirements
- R1: After reset the counter, load, match, capture, control, status and enable registers all read 0, and irq is low.
- R2: The registers sit at these byte offsets: status 0x18, enable 0x1C, control 0x24, counter 0x28, load 0x2C, match 0x38, capture 0x3C. Counter, load and match read back what was written. Unmapped offsets read 0.
- R3: In RUN, the counter increments by one on each clock where count_tick is high and the prescaler fires. In HALT, or with count_tick low, the counter holds.
- R4: When the counter advances from 0xFFFFFFFF, it takes the load register value on the next clock and sets status bit1 (overflow).
- R5: On that wrap with auto-reload off (control bit1 = 0), the machine goes to HALT and control bit0 reads 0. With auto-reload on, it stays in RUN and keeps counting from the load value.
- R6: With control bit5 set, the counter advances once every 2^(P+1) ticks, where P is control bits[4:2]. The prescaler is held cleared in HALT, so the first advance after a start comes 2^(P+1) ticks after the start edge. With bit5 clear, every tick advances the counter.
- R7: With control bit6 set, an advance taken while the counter equals the match register loads the load value instead of incrementing, and sets status bit2 (match).
- R8: cap_in passes through a two-flop synchronizer. A synchronized edge selected by control bits[9:8] (01 rising, 10 falling, 11 both, 00 none) copies the counter into the capture register and sets status bit0, three clocks after the pin changes.
- R9: Writing the status register clears each flag whose data bit is 1 and leaves flags written with 0 unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R10: irq is high exactly when some status flag is set together with its enable bit (same bit positions as the status register).
- R11: A software write to the counter register takes priority over a count advance in the same cycle, and it suppresses any wrap or match event in that cycle.
- R12: Writing control bit0 = 1 moves HALT to RUN. Writing it as 0 moves RUN to HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_tick | input | 1 | Count enable pulse, one per timer tick |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Level interrupt request |

## Verification
The bound assertions check the following on every clock:
- The counter holds whenever no advance and no software write occurs.
- Each wrap loads the earlier load value and raises the overflow flag, even when a clear of that flag arrives in the same cycle.
- A one-shot wrap ends in HALT.
- A compare hit sets the match flag.
- A status clear with no competing event takes effect.
- irq only rises when a flag is set.

The prescaler ratios, the capture edge selection through the synchronizer, the auto-reload continuation and the priority of counter writes depend on exact cycle counts and chosen values. Only the directed scenarios of the bench show these.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CONTROL = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_COUNTER = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD    = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_MATCH   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_CAPTURE = 8'h3C;

    // event source bit positions shared by status and enable
    localparam int EV_CAP   = 0;
    localparam int EV_OVF   = 1;
    localparam int EV_MATCH = 2;
    localparam int N_EVENTS = 3;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clear,
    input  logic             tick,
    input  logic             div_en,
    input  logic [PTV_W-1:0] div_sel,
    output logic             advance
);
    localparam int PCNT_W = 1 << PTV_W;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W:0]   limit_wide;
    logic              at_limit;

    always_comb begin
        limit_wide = ({{PCNT_W{1'b0}}, 1'b1} << ({1'b0, div_sel} + 1'b1)) - 1'b1;
        at_limit   = (pcnt_q == limit_wide[PCNT_W-1:0]);
        advance    = !hold_clear && tick && (!div_en || at_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (hold_clear || !div_en) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= at_limit ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= pin;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        rise = sync_q[SYNC_STAGES-1] && !prev_q;
        fall = !sync_q[SYNC_STAGES-1] && prev_q;
        hit  = (edge_sel[0] && rise) || (edge_sel[1] && fall);
    end
endmodule

// File: rtl/gpt_flags.sv
module gpt_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic         sw_clr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] clr_eff;

    always_comb clr_eff = sw_clr ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_eff) | hw_set;
    end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PTV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              irq
);
    localparam int CTRL_W = 10;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e state_q, state_d;

    logic [CNT_W-1:0]    cnt_q, load_q, match_q, capt_q;
    logic                auto_q, pre_q, cmp_q;
    logic [PTV_W-1:0]    ptv_q;
    logic [1:0]          edge_q;
    logic [N_EVENTS-1:0] ien_q, sts, ev_set;
    logic                run, adv, cap_hit;
    logic                wr_ctrl, wr_cnt, wr_sts, wr_ien, wr_load, wr_match;
    logic                wrap_ev, match_ev;
    logic [CTRL_W-1:0]   ctrl_view;

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == OFS_CONTROL);
        wr_cnt   = bus_wr && (bus_addr == OFS_COUNTER);
        wr_sts   = bus_wr && (bus_addr == OFS_STATUS);
        wr_ien   = bus_wr && (bus_addr == OFS_ENABLE);
        wr_load  = bus_wr && (bus_addr == OFS_LOAD);
        wr_match = bus_wr && (bus_addr == OFS_MATCH);
    end

    gpt_prescaler #(.PTV_W(PTV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .hold_clear(!run), .tick(count_tick),
        .div_en(pre_q), .div_sel(ptv_q), .advance(adv)
    );

    gpt_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capt (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .edge_sel(edge_q), .hit(cap_hit)
    );

    always_comb begin
        wrap_ev  = adv && !wr_cnt && (cnt_q == CNT_MAX);
        match_ev = adv && !wr_cnt && cmp_q && (cnt_q == match_q);
        ev_set   = '0;
        ev_set[EV_CAP]   = cap_hit;
        ev_set[EV_OVF]   = wrap_ev;
        ev_set[EV_MATCH] = match_ev;
    end

    gpt_flags #(.N(N_EVENTS)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(ev_set), .sw_clr(wr_sts),
        .clr_mask(bus_wdata[N_EVENTS-1:0]), .flags(sts)
    );

    // run-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (wr_ctrl && bus_wdata[0]) state_d = ST_RUN;
            ST_RUN: begin
                if (wr_ctrl)                state_d = bus_wdata[0] ? ST_RUN : ST_HALT;
                else if (wrap_ev && !auto_q) state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // state outputs
    always_comb run = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b0; pre_q <= 1'b0; cmp_q <= 1'b0;
            ptv_q  <= '0;   edge_q <= '0;  ien_q <= '0;
            load_q <= '0;   match_q <= '0;
        end else begin
            if (wr_ctrl) begin
                auto_q <= bus_wdata[1];
                ptv_q  <= bus_wdata[2 +: PTV_W];
                pre_q  <= bus_wdata[5];
                cmp_q  <= bus_wdata[6];
                edge_q <= bus_wdata[9:8];
            end
            if (wr_ien)   ien_q   <= bus_wdata[N_EVENTS-1:0];
            if (wr_load)  load_q  <= bus_wdata;
            if (wr_match) match_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (wr_cnt)              cnt_q <= bus_wdata;
        else if (wrap_ev || match_ev) cnt_q <= load_q;
        else if (adv)                 cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       capt_q <= '0;
        else if (cap_hit) capt_q <= cnt_q;
    end

    always_comb begin
        ctrl_view = {edge_q, 1'b0, cmp_q, pre_q, ptv_q, auto_q, run};
        unique case (bus_addr)
            OFS_STATUS:  bus_rdata = {{(CNT_W-N_EVENTS){1'b0}}, sts};
            OFS_ENABLE:  bus_rdata = {{(CNT_W-N_EVENTS){1'b0}}, ien_q};
            OFS_CONTROL: bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_view};
            OFS_COUNTER: bus_rdata = cnt_q;
            OFS_LOAD:    bus_rdata = load_q;
            OFS_MATCH:   bus_rdata = match_q;
            OFS_CAPTURE: bus_rdata = capt_q;
            default:     bus_rdata = '0;
        endcase
        irq = |(sts & ien_q);
    end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             adv,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load,
    input logic [CNT_W-1:0] match,
    input logic             auto_rl,
    input logic             cmp_en,
    input logic [2:0]       sts,
    input logic             wr_cnt,
    input logic             wr_ctrl,
    input logic             wr_sts,
    input logic [CNT_W-1:0] wdata,
    input logic             irq
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R3 / R11: counter only moves on an advance or a software write
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_cnt) |=> (cnt == $past(cnt)));

    // R4 and R9 (set wins): wrap reloads and raises overflow
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && cnt == TOP) |=> (cnt == $past(load) && sts[1]));

    // R5: one-shot wrap halts
    a_r5_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && cnt == TOP && !auto_rl && !wr_ctrl) |=> !run);

    // R7: compare hit sets match flag
    a_r7_match: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && cmp_en && cnt == match) |=> sts[2]);

    // R9: uncontested clear of overflow takes effect
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[1] && !(adv && !wr_cnt && cnt == TOP)) |=> !sts[1]);

    // R10: interrupt needs a set flag
    a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != 3'b000));
endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .adv(adv), .cnt(cnt_q),
    .load(load_q), .match(match_q), .auto_rl(auto_q), .cmp_en(cmp_q),
    .sts(sts), .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl), .wr_sts(wr_sts),
    .wdata(bus_wdata), .irq(irq)
);

// File: tb/gpt_timer_test.sv
module gpt_timer_test;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_tick = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    gpt_timer uut (
        .clk(clk), .rst_n(rst_n), .count_tick(count_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %h got %h exp %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        chk_rd("R1", 8'h28, 0); chk_rd("R1", 8'h24, 0); chk_rd("R1", 8'h18, 0);
        chk_rd("R1", 8'h3C, 0); chk_bit("R1 irq", irq, 1'b0);
    endtask

    task automatic t_regs;
        wr(8'h28, 32'h1234); wr(8'h2C, 32'hCAFE); wr(8'h38, 32'h99);
        repeat (4) @(posedge clk); @(negedge clk);
        chk_rd("R2 counter", 8'h28, 32'h1234);
        chk_rd("R2 load", 8'h2C, 32'hCAFE);
        chk_rd("R2 match", 8'h38, 32'h99);
        chk_rd("R2 unmapped", 8'h40, 0);
        chk_rd("R3 halted hold", 8'h28, 32'h1234);
    endtask

    task automatic t_count;
        wr(8'h28, 32'd100); wr(8'h24, 32'h1);
        repeat (10) @(posedge clk); @(negedge clk);
        chk_rd("R3 count", 8'h28, 32'd110);
        chk_rd("R12 run", 8'h24, 32'h1);
        count_tick = 1'b0;
        repeat (5) @(posedge clk); @(negedge clk);
        chk_rd("R3 tick low", 8'h28, 32'd110);
        count_tick = 1'b1;
        wr(8'h28, 32'h500);
        repeat (2) @(posedge clk); @(negedge clk);
        chk_rd("R11 sw write", 8'h28, 32'h502);
        wr(8'h24, 32'h0);
        chk_rd("R12 halt", 8'h24, 32'h0);
    endtask

    task automatic t_oneshot;
        wr(8'h1C, 32'h2); wr(8'h2C, 32'h50); wr(8'h28, 32'hFFFF_FFFD);
        wr(8'h24, 32'h1);
        repeat (5) @(posedge clk); @(negedge clk);
        chk_rd("R4 reload", 8'h28, 32'h50);
        chk_rd("R4 ovf flag", 8'h18, 32'h2);
        chk_rd("R5 stopped", 8'h24, 32'h0);
        chk_bit("R10 irq", irq, 1'b1);
        wr(8'h18, 32'h0);
        chk_rd("R9 zero write", 8'h18, 32'h2);
        wr(8'h18, 32'h2);
        chk_rd("R9 w1c", 8'h18, 32'h0);
        chk_bit("R10 irq clear", irq, 1'b0);
    endtask

    task automatic t_autoreload;
        wr(8'h2C, 32'hFFFF_FFF0); wr(8'h28, 32'hFFFF_FFFE); wr(8'h24, 32'h3);
        repeat (3) @(posedge clk); @(negedge clk);
        chk_rd("R5 autoreload count", 8'h28, 32'hFFFF_FFF1);
        chk_rd("R5 autoreload run", 8'h24, 32'h3);
        wr(8'h24, 32'h0); wr(8'h18, 32'h7);
    endtask

    task automatic t_prescale;
        wr(8'h28, 32'h0); wr(8'h24, 32'h21);
        repeat (10) @(posedge clk); @(negedge clk);
        chk_rd("R6 div2", 8'h28, 32'd5);
        wr(8'h24, 32'h0); wr(8'h28, 32'h0); wr(8'h24, 32'h3D);
        repeat (255) @(posedge clk); @(negedge clk);
        chk_rd("R6 div256 before", 8'h28, 32'd0);
        @(posedge clk); @(negedge clk);
        chk_rd("R6 div256 at", 8'h28, 32'd1);
        wr(8'h24, 32'h0);
    endtask

    task automatic t_compare;
        wr(8'h2C, 32'h10); wr(8'h38, 32'h14); wr(8'h28, 32'h12);
        wr(8'h24, 32'h43);
        repeat (3) @(posedge clk); @(negedge clk);
        chk_rd("R7 reload", 8'h28, 32'h10);
        chk_rd("R7 flag", 8'h18, 32'h4);
        wr(8'h24, 32'h0); wr(8'h18, 32'h4);
    endtask

    task automatic t_capture;
        wr(8'h28, 32'hABCD); wr(8'h24, 32'h100);
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(posedge clk); @(negedge clk);
        chk_rd("R8 rising", 8'h3C, 32'hABCD);
        chk_rd("R8 flag", 8'h18, 32'h1);
        wr(8'h18, 32'h1); wr(8'h28, 32'h77);
        @(negedge clk); cap_in = 1'b0;
        repeat (4) @(posedge clk); @(negedge clk);
        chk_rd("R8 falling ignored", 8'h3C, 32'hABCD);
        chk_rd("R8 no flag", 8'h18, 32'h0);
        wr(8'h24, 32'h300);
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(posedge clk); @(negedge clk);
        chk_rd("R8 both", 8'h3C, 32'h77);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_oneshot();
        t_autoreload();
        t_prescale();
        t_compare();
        t_capture();
        finish_run();
    end
endmodule